// File: doc/BRIEF.md
# Lockable System Control Register File

This block is a word-addressed control register file that sits in a 4 KB window of a simple 32-bit register bus. It keeps a volatile flag word and a retained flag word, each changed only through a pair of set and clear addresses. It holds configurable data words, read-only processor identity words and a free-running tick counter that software can sample. The counter advances on a tick-enable strobe that paces it to 24 MHz from the block clock.

A 16-bit key guards the reset-control register. Software writes the key to the lock register to open the block. Any other value written there is stored with bit 15 cleared, so it can never equal the key, and the block closes. While the block is open, a write to reset-control stores a reset level and raises the system reset request output for exactly one cycle.

There are two reset inputs. The system reset clears the lock, the volatile flags, the counter and the read register. The power-on reset also clears the retained flags, the configuration words and the reset level, which otherwise survive a system reset.

Top module: `sysctl_regfile`

## Requirements
- R1: Writing exactly 32'h0000A05F to offset 0x20 unlocks the block. A read of 0x20 then returns 32'h0000A05F: bits [15:0] hold the stored value and bit 16 is 0.
- R2: Writing any other 32-bit value to 0x20 stores (value & 0x7FFF) in bits [15:0] and locks the block. A read of 0x20 returns that value with bit 16 set. This includes 32'hFFFFA05F, which reads back as 32'h0001205F.
- R3: A write to 0x40 while the block is unlocked stores wdata[7:0] as the reset level, which reads back at 0x40 zero-extended. sys_rst_req is high for exactly the one cycle after that write. While the block is locked, a write to 0x40 changes nothing and raises no request.
- R4: Offset 0x30 reads the volatile flag word. A write to 0x30 ORs wdata into it, and a write to 0x34 clears the bits set in wdata.
- R5: Offset 0x38 reads the retained flag word. A write to 0x38 ORs wdata into it, and a write to 0x3C clears the bits set in wdata.
- R6: Offset 0x5C reads a 32-bit counter that adds one on every clock cycle with tick_en high and holds otherwise.
- R7: Offsets 0x28 and 0x2C are two 32-bit read/write configuration words.
- R8: Offsets 0x84 and 0x88 return the PROC_ID0 and PROC_ID1 parameter values, and writes to them are ignored.
- R9: Every offset not listed in R1 to R8 reads as zero and ignores writes. This includes the clear addresses 0x34 and 0x3C, and 0x100 and 0xFFC.
- R10: rdata is registered. It takes the addressed value at the clock edge where rd_en is sampled high and holds its value in every cycle without rd_en, including across writes.
- R11: After reset, 0x20 reads 32'h00010000 (locked), and the volatile flags, the counter and rdata are zero. A system reset alone (rst_n low, por_n high) leaves the retained flags, the configuration words and the reset level unchanged. por_n low clears those as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, clears all state |
| tick_en | input | 1 | Counter advance strobe (24 MHz rate) |
| addr | input | 10 | Word address, byte offset bits [11:2] |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that wr_en and rd_en are low while either reset is asserted, and that tick_en is low during reset. They also assume that addr and wdata are free of X whenever a strobe is high. The bench drives every strobe at the falling edge, keeps all strobes low through both reset phases and the system-reset-only pulse, and never raises rd_en and wr_en in the same cycle. Because of this, a $past term never reaches back to an access made during reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned KEY_W  = 16;

   typedef logic [ADDR_W-1:0] word_addr_t;
   typedef logic [DATA_W-1:0] word_t;

   // word indices (byte offset >> 2)
   localparam word_addr_t WA_LOCK   = 10'h008;
   localparam word_addr_t WA_CFG    = 10'h00A;
   localparam word_addr_t WA_VF_SET = 10'h00C;
   localparam word_addr_t WA_VF_CLR = 10'h00D;
   localparam word_addr_t WA_RF_SET = 10'h00E;
   localparam word_addr_t WA_RF_CLR = 10'h00F;
   localparam word_addr_t WA_RSTCTL = 10'h010;
   localparam word_addr_t WA_TICK   = 10'h017;
   localparam word_addr_t WA_ID0    = 10'h021;
   localparam word_addr_t WA_ID1    = 10'h022;

   localparam word_t            UNLOCK_KEY = 32'h0000_A05F;
   localparam logic [KEY_W-1:0] KEEP_MASK  = 16'h7FFF;
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
   import sysctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  word_t            wdata,
   output logic [KEY_W-1:0] lock_q,
   output logic             unlocked
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= '0;
      end else if (wr) begin
         if (wdata == UNLOCK_KEY)
            lock_q <= UNLOCK_KEY[KEY_W-1:0];
         else
            lock_q <= wdata[KEY_W-1:0] & KEEP_MASK;
      end
   end

   assign unlocked = (lock_q == UNLOCK_KEY[KEY_W-1:0]);
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (set_en)
         q <= q | bits;
      else if (clr_en)
         q <= q & ~bits;
   end
endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl #(
   parameter int unsigned LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             wr,
   input  logic             unlocked,
   input  logic [LVL_W-1:0] level_in,
   output logic [LVL_W-1:0] level_q,
   output logic             req_q
);
   logic take;
   assign take = wr && unlocked;

   always_ff @(posedge clk) begin
      if (!por_n)
         level_q <= '0;
      else if (take)
         level_q <= level_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         req_q <= 1'b0;
      else
         req_q <= take;
   end
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   output logic [W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_en)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int unsigned VF_W     = 32,
   parameter int unsigned RF_W     = 32,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned RSTLVL_W = 8,
   parameter int unsigned NUM_CFG  = 2,
   parameter logic [31:0] PROC_ID0 = 32'h5A00_0001,
   parameter logic [31:0] PROC_ID1 = 32'h5A00_0002
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        por_n,
   input  logic        tick_en,
   input  logic [9:0]  addr,
   input  logic [31:0] wdata,
   input  logic        wr_en,
   input  logic        rd_en,
   output logic [31:0] rdata,
   output logic        sys_rst_req
);
   // system reset also follows power-on reset
   logic sys_n;
   assign sys_n = rst_n & por_n;

   logic [KEY_W-1:0]    lock_q;
   logic                unlocked;
   logic [VF_W-1:0]     vflags_q;
   logic [RF_W-1:0]     rflags_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [RSTLVL_W-1:0] rstlvl_q;
   word_t               cfg_q [NUM_CFG];
   word_t               rd_mux;

   sysctl_lock u_lock (
      .clk      (clk),
      .rst_n    (sys_n),
      .wr       (wr_en && addr == WA_LOCK),
      .wdata    (wdata),
      .lock_q   (lock_q),
      .unlocked (unlocked)
   );

   sysctl_setclr #(.W(VF_W)) u_vflags (
      .clk    (clk),
      .rst_n  (sys_n),
      .set_en (wr_en && addr == WA_VF_SET),
      .clr_en (wr_en && addr == WA_VF_CLR),
      .bits   (wdata[VF_W-1:0]),
      .q      (vflags_q)
   );

   sysctl_setclr #(.W(RF_W)) u_rflags (
      .clk    (clk),
      .rst_n  (por_n),
      .set_en (wr_en && addr == WA_RF_SET),
      .clr_en (wr_en && addr == WA_RF_CLR),
      .bits   (wdata[RF_W-1:0]),
      .q      (rflags_q)
   );

   sysctl_rstctl #(.LVL_W(RSTLVL_W)) u_rstctl (
      .clk      (clk),
      .rst_n    (sys_n),
      .por_n    (por_n),
      .wr       (wr_en && addr == WA_RSTCTL),
      .unlocked (unlocked),
      .level_in (wdata[RSTLVL_W-1:0]),
      .level_q  (rstlvl_q),
      .req_q    (sys_rst_req)
   );

   sysctl_tick #(.W(CNT_W)) u_tick (
      .clk     (clk),
      .rst_n   (sys_n),
      .tick_en (tick_en),
      .cnt_q   (cnt_q)
   );

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!por_n)
            cfg_q[g] <= '0;
         else if (wr_en && addr == WA_CFG + ADDR_W'(g))
            cfg_q[g] <= wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         WA_LOCK:   rd_mux = {15'b0, ~unlocked, lock_q};
         WA_VF_SET: rd_mux = DATA_W'(vflags_q);
         WA_RF_SET: rd_mux = DATA_W'(rflags_q);
         WA_RSTCTL: rd_mux = DATA_W'(rstlvl_q);
         WA_TICK:   rd_mux = DATA_W'(cnt_q);
         WA_ID0:    rd_mux = PROC_ID0;
         WA_ID1:    rd_mux = PROC_ID1;
         default:   rd_mux = '0;
      endcase
      for (int i = 0; i < NUM_CFG; i++) begin
         if (addr == WA_CFG + ADDR_W'(i))
            rd_mux = cfg_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!sys_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_mux;
   end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
   import sysctl_pkg::*;
#(
   parameter int unsigned VF_W     = 32,
   parameter int unsigned RF_W     = 32,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned RSTLVL_W = 8,
   parameter int unsigned NUM_CFG  = 2,
   parameter logic [31:0] PROC_ID0 = 32'h0,
   parameter logic [31:0] PROC_ID1 = 32'h0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             por_n,
   input logic             tick_en,
   input logic [9:0]       addr,
   input logic [31:0]      wdata,
   input logic             wr_en,
   input logic             rd_en,
   input logic [31:0]      rdata,
   input logic             sys_rst_req,
   input logic [KEY_W-1:0] lock_q,
   input logic [VF_W-1:0]  vflags_q,
   input logic [RF_W-1:0]  rflags_q,
   input logic [CNT_W-1:0] cnt_q
);
   initial begin
      a_widths: assert (VF_W >= 1 && VF_W <= 32 && RF_W >= 1 && RF_W <= 32 &&
                        CNT_W >= 1 && CNT_W <= 32 && RSTLVL_W >= 1 &&
                        RSTLVL_W <= 32 && NUM_CFG >= 1 && NUM_CFG <= 2);
   end

   p_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_en && addr == WA_LOCK && wdata == UNLOCK_KEY) |=> lock_q == 16'hA05F);

   p_nokey_locks_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_en && addr == WA_LOCK && wdata != UNLOCK_KEY) |=> lock_q[15] == 1'b0);

   p_req_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      sys_rst_req |-> $past(wr_en && addr == WA_RSTCTL && lock_q == 16'hA05F));

   p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      sys_rst_req |=> !sys_rst_req);

   p_vflag_set_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_en && addr == WA_VF_SET) |=> (vflags_q & $past(wdata[VF_W-1:0])) == $past(wdata[VF_W-1:0]));

   p_vflag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_en && addr == WA_VF_CLR) |=> (vflags_q & $past(wdata[VF_W-1:0])) == '0);

   p_rflag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (wr_en && addr == WA_RF_CLR) |=> (rflags_q & $past(wdata[RF_W-1:0])) == '0);

   p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !tick_en |=> $stable(cnt_q));

   p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      tick_en |=> cnt_q == $past(cnt_q) + 1'b1);

   p_id_read_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (rd_en && addr == WA_ID0) |=> rdata == PROC_ID0);

   p_id1_read_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (rd_en && addr == WA_ID1) |=> rdata == PROC_ID1);

   p_high_zero_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (rd_en && addr >= 10'h040) |=> rdata == '0);

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !rd_en |=> $stable(rdata));
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
   .VF_W(VF_W), .RF_W(RF_W), .CNT_W(CNT_W), .RSTLVL_W(RSTLVL_W),
   .NUM_CFG(NUM_CFG), .PROC_ID0(PROC_ID0), .PROC_ID1(PROC_ID1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en),
   .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
   .rdata(rdata), .sys_rst_req(sys_rst_req), .lock_q(lock_q),
   .vflags_q(vflags_q), .rflags_q(rflags_q), .cnt_q(cnt_q)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
   localparam logic [31:0] ID0 = 32'h5A00_0001;
   localparam logic [31:0] ID1 = 32'h5A00_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic        sys_rst_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sysctl_regfile #(.PROC_ID0(ID0), .PROC_ID1(ID1)) u_dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en),
      .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
      .rdata(rdata), .sys_rst_req(sys_rst_req)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] off;
      logic [31:0] dat;   // write data, or expected read value
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 12'h020, 32'h0001_0000},  // R11 locked after reset
      '{1'b1, 12'h020, 32'h0000_A05F},  // R1 key
      '{1'b0, 12'h020, 32'h0000_A05F},  // R1
      '{1'b1, 12'h030, 32'h0000_F00F},  // R4 set
      '{1'b1, 12'h030, 32'h0000_0F00},  // R4 set, OR
      '{1'b0, 12'h030, 32'h0000_FF0F},  // R4
      '{1'b1, 12'h034, 32'h0000_000F},  // R4 clear
      '{1'b0, 12'h030, 32'h0000_FF00},  // R4
      '{1'b1, 12'h038, 32'h1234_0000},  // R5 set
      '{1'b1, 12'h03C, 32'h0004_0000},  // R5 clear
      '{1'b0, 12'h038, 32'h1230_0000},  // R5
      '{1'b1, 12'h028, 32'hDEAD_BEEF},  // R7
      '{1'b1, 12'h02C, 32'h0BAD_F00D},  // R7
      '{1'b0, 12'h028, 32'hDEAD_BEEF},  // R7
      '{1'b0, 12'h02C, 32'h0BAD_F00D},  // R7
      '{1'b1, 12'h084, 32'h0000_0000},  // R8 write ignored
      '{1'b0, 12'h084, 32'h5A00_0001},  // R8
      '{1'b0, 12'h088, 32'h5A00_0002},  // R8
      '{1'b1, 12'h100, 32'hFFFF_FFFF},  // R9 write ignored
      '{1'b0, 12'h100, 32'h0000_0000},  // R9
      '{1'b0, 12'h034, 32'h0000_0000},  // R9 clear address reads zero
      '{1'b0, 12'hFFC, 32'h0000_0000}   // R9
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] off, input logic [31:0] d);
      @(negedge clk);
      addr = off[11:2]; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] off, output logic [31:0] d);
      @(negedge clk);
      addr = off[11:2]; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;
      @(negedge clk);
      check("R11 rdata after reset", rdata, 32'h0);
      bus_rd(12'h030, v); check("R11 flags after reset", v, 32'h0);
      bus_rd(12'h05C, v); check("R11 counter after reset", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) bus_wr(VEC[i].off, VEC[i].dat);
         else begin
            bus_rd(VEC[i].off, v);
            check($sformatf("vector %0d offset %h", i, VEC[i].off), v, VEC[i].dat);
         end
      end

      // R2 non-key values
      bus_wr(12'h020, 32'h1234_FFFF);
      bus_rd(12'h020, v); check("R2 masked lock value", v, 32'h0001_7FFF);
      bus_wr(12'h020, 32'hFFFF_A05F);
      bus_rd(12'h020, v); check("R2 key in low half only", v, 32'h0001_205F);

      // R3 locked: no effect
      bus_wr(12'h040, 32'h0000_003C);
      check("R3 no request when locked", {31'b0, sys_rst_req}, 32'h0);
      @(negedge clk);
      check("R3 no request when locked", {31'b0, sys_rst_req}, 32'h0);
      bus_rd(12'h040, v); check("R3 level unchanged when locked", v, 32'h0);
      // R3 unlocked: one-cycle pulse
      bus_wr(12'h020, 32'h0000_A05F);
      bus_wr(12'h040, 32'h0000_01A5);
      check("R3 request raised", {31'b0, sys_rst_req}, 32'h1);
      @(negedge clk);
      check("R3 request one cycle", {31'b0, sys_rst_req}, 32'h0);
      bus_rd(12'h040, v); check("R3 level stored", v, 32'h0000_00A5);

      // R10 read register holds
      bus_rd(12'h028, v);
      repeat (3) @(negedge clk);
      check("R10 hold without rd_en", rdata, 32'hDEAD_BEEF);
      bus_wr(12'h028, 32'h1111_1111);
      check("R10 hold across write", rdata, 32'hDEAD_BEEF);
      bus_rd(12'h028, v); check("R10 new read", v, 32'h1111_1111);

      // R11 system reset only
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      bus_rd(12'h020, v); check("R11 lock after system reset", v, 32'h0001_0000);
      bus_rd(12'h030, v); check("R11 flags cleared", v, 32'h0);
      bus_rd(12'h038, v); check("R11 retained flags kept", v, 32'h1230_0000);
      bus_rd(12'h028, v); check("R11 config kept", v, 32'h1111_1111);
      bus_rd(12'h040, v); check("R11 level kept", v, 32'h0000_00A5);

      // R6 counter
      bus_rd(12'h05C, v); check("R6 counter idle", v, 32'h0);
      @(negedge clk); tick_en = 1'b1;
      repeat (10) @(negedge clk);
      tick_en = 1'b0;
      bus_rd(12'h05C, v); check("R6 counter ten ticks", v, 32'd10);
      repeat (5) @(negedge clk);
      bus_rd(12'h05C, v); check("R6 counter holds", v, 32'd10);

      // R11 power-on reset clears retained state
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk); por_n = 1'b1;
      bus_rd(12'h038, v); check("R11 por clears retained flags", v, 32'h0);
      bus_rd(12'h02C, v); check("R11 por clears config", v, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule